// File: doc/BRIEF.md
# Two-Path Key Sequence Write Guard

This block guards two register paths of a non-volatile memory controller: the main control path and the path that updates the stored configuration (option) words. Each path is opened by its own key register on a simple write bus. Software must write the first key and then the second key to that key register. Only then does the path report itself open and raise its write qualifier. Any unexpected value written to a key register closes the path for good, until the next reset, and raises a bus error pulse in the same cycle as the offending write.

The control register sits behind the control path. It holds a protected field, which only takes writes while the control path is open, and two relock bits. Software relocks a path by writing one of those bits. A later correct key sequence then opens the path again. Downstream logic uses the two qualifier outputs to allow or block writes to the registers it protects. The memory array, its timing and the option storage live outside this block.

Top module: `key_lock_guard`

## Requirements
- R1: While reset is high, and in the first cycle after it, both paths report locked, both write qualifiers are low and the protected control field reads zero.
- R2: A write of KEY_A (default 0x45670123) followed by a write of KEY_B (default 0xCDEF89AB) to address 0 opens the control path. `ctrl_locked` goes low in the cycle after the KEY_B write.
- R3: A key write of anything other than KEY_A to a closed path raises `bus_err` in that write's cycle and bars the path. So does anything other than KEY_B right after KEY_A, including KEY_B written first.
- R4: A barred path stays locked until reset. A correct key sequence does not open it, and every key write to it raises `bus_err`.
- R5: Any key write to a path that is already open raises `bus_err` and bars that path.
- R6: The option path uses the same key values and rules at address 1. It is fully independent: key writes to one path never change the other path's state.
- R7: A control register write (address 2) with bit 31 set, made while the control path is open, locks the control path from the next cycle. The path can then be reopened with the key sequence.
- R8: The protected field, bits [CTRL_W-1:0] of the control register, is written only while the control path is open. While the control path is locked, writes to it are ignored.
- R9: A control register write made while the control path is open relocks the option path when bit 30 is 1 (OPT_FLAG_MODE=0) or 0 (OPT_FLAG_MODE=1). While the control path is locked, this bit is ignored.
- R10: `ctrl_wr_ok` is high exactly when the control path is open. `opt_wr_ok` is high only when both paths are open.
- R11: `bus_err` stays low for writes to address 2 or 3 and in cycles with no write. Writes to other addresses between KEY_A and KEY_B do not break the key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Word address: 0 control key, 1 option key, 2 control register, 3 unused |
| bus_wdata | input | 32 | Write data |
| ctrl_locked | output | 1 | Control path is not open |
| opt_locked | output | 1 | Option path is not open |
| ctrl_wr_ok | output | 1 | Write qualifier for control-protected registers |
| opt_wr_ok | output | 1 | Write qualifier for option-protected registers |
| ctrl_field | output | CTRL_W | Protected field of the control register |
| bus_err | output | 1 | Error response, same cycle as a rejected key write |

## Verification
The assertions assume that `bus_wr` is a single-cycle strobe that presents one address per cycle, so at most one key path can be hit in a cycle. They also assume the address and data are stable while the strobe is high. The stimulus issues each write as an isolated one-cycle strobe with an idle cycle after it. It checks the error pulse during the write and the lock state in the idle cycle that follows. The stimulus never drives overlapping writes, so the error output can be attributed to a single write.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 2;
    localparam int NPATH  = 2;

    typedef logic [ADDR_W-1:0] reg_addr_t;
    typedef logic [BUS_W-1:0]  bus_word_t;

    localparam reg_addr_t ADR_CTRL_KEY = 2'd0;
    localparam reg_addr_t ADR_OPT_KEY  = 2'd1;
    localparam reg_addr_t ADR_CTRL_REG = 2'd2;

    localparam int BIT_CTRL_RELOCK = 31;
    localparam int BIT_OPT_RELOCK  = 30;

    localparam int PATH_CTRL = 0;
    localparam int PATH_OPT  = 1;

    typedef enum logic [1:0] {
        KS_SHUT   = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2,
        KS_BARRED = 2'd3
    } key_state_e;

    typedef struct packed {
        key_state_e nxt;
        logic       bad;
    } key_step_t;

    function automatic reg_addr_t path_key_addr(input int path);
        return (path == PATH_CTRL) ? ADR_CTRL_KEY : ADR_OPT_KEY;
    endfunction

    function automatic key_step_t key_step(input key_state_e s,
                                           input bus_word_t  d,
                                           input bus_word_t  k_first,
                                           input bus_word_t  k_second);
        key_step_t r;
        r.nxt = KS_BARRED;
        r.bad = 1'b1;
        case (s)
            KS_SHUT: if (d == k_first) begin
                r.nxt = KS_HALF;
                r.bad = 1'b0;
            end
            KS_HALF: if (d == k_second) begin
                r.nxt = KS_OPEN;
                r.bad = 1'b0;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/key_seq_fsm.sv
module key_seq_fsm
    import lock_pkg::*;
#(
    parameter logic [31:0] KEY_A = 32'h4567_0123,
    parameter logic [31:0] KEY_B = 32'hCDEF_89AB
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      key_wr,
    input  bus_word_t wdata,
    input  logic      relock,
    output logic      is_open,
    output logic      bad_key
);

    key_state_e st;
    key_state_e st_n;
    key_step_t  step;

    always_comb begin
        step    = key_step(st, wdata, KEY_A, KEY_B);
        st_n    = st;
        bad_key = 1'b0;
        if (key_wr) begin
            st_n    = step.nxt;
            bad_key = step.bad;
        end else if (relock && st == KS_OPEN) begin
            st_n = KS_SHUT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= KS_SHUT;
        else     st <= st_n;
    end

    assign is_open = (st == KS_OPEN);

    a_r4_barred_sticky: assert property (@(posedge clk) disable iff (rst)
        st == KS_BARRED |=> st == KS_BARRED);

    a_r2_open_needs_second_key: assert property (@(posedge clk) disable iff (rst)
        $rose(is_open) |-> ($past(st) == KS_HALF && $past(key_wr) && $past(wdata) == KEY_B));

    a_r3_bad_bars_path: assert property (@(posedge clk) disable iff (rst)
        bad_key |=> st == KS_BARRED);

endmodule

// File: rtl/ctrl_reg_file.sv
module ctrl_reg_file
    import lock_pkg::*;
#(
    parameter int CTRL_W        = 16,
    parameter bit OPT_FLAG_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  bus_word_t         wdata,
    input  logic              ctrl_open,
    output logic [CTRL_W-1:0] field,
    output logic              ctrl_relock,
    output logic              opt_relock
);

    logic take;
    logic opt_req;

    assign take = wr && ctrl_open;

    generate
        if (OPT_FLAG_MODE) begin : g_clear_flag
            assign opt_req = ~wdata[BIT_OPT_RELOCK];
        end else begin : g_set_bit
            assign opt_req = wdata[BIT_OPT_RELOCK];
        end
    endgenerate

    assign ctrl_relock = take && wdata[BIT_CTRL_RELOCK];
    assign opt_relock  = take && opt_req;

    always_ff @(posedge clk) begin
        if (rst)       field <= '0;
        else if (take) field <= wdata[CTRL_W-1:0];
    end

    a_r8_field_frozen: assert property (@(posedge clk) disable iff (rst)
        !ctrl_open |=> $stable(field));

    a_r9_opt_relock_needs_ctrl: assert property (@(posedge clk) disable iff (rst)
        opt_relock |-> ctrl_open);

endmodule

// File: rtl/key_lock_guard.sv
module key_lock_guard
    import lock_pkg::*;
#(
    parameter logic [31:0] KEY_A         = 32'h4567_0123,
    parameter logic [31:0] KEY_B         = 32'hCDEF_89AB,
    parameter int          CTRL_W        = 16,
    parameter bit          OPT_FLAG_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              ctrl_locked,
    output logic              opt_locked,
    output logic              ctrl_wr_ok,
    output logic              opt_wr_ok,
    output logic [CTRL_W-1:0] ctrl_field,
    output logic              bus_err
);

    logic [NPATH-1:0] path_open;
    logic [NPATH-1:0] path_bad;
    logic [NPATH-1:0] path_relock;
    logic             ctrl_wr;

    assign ctrl_wr = bus_wr && (bus_addr == ADR_CTRL_REG);

    ctrl_reg_file #(
        .CTRL_W        (CTRL_W),
        .OPT_FLAG_MODE (OPT_FLAG_MODE)
    ) u_creg (
        .clk         (clk),
        .rst         (rst),
        .wr          (ctrl_wr),
        .wdata       (bus_wdata),
        .ctrl_open   (path_open[PATH_CTRL]),
        .field       (ctrl_field),
        .ctrl_relock (path_relock[PATH_CTRL]),
        .opt_relock  (path_relock[PATH_OPT])
    );

    generate
        for (genvar p = 0; p < NPATH; p++) begin : g_path
            logic hit;
            assign hit = bus_wr && (bus_addr == path_key_addr(p));
            key_seq_fsm #(
                .KEY_A (KEY_A),
                .KEY_B (KEY_B)
            ) u_fsm (
                .clk     (clk),
                .rst     (rst),
                .key_wr  (hit),
                .wdata   (bus_wdata),
                .relock  (path_relock[p]),
                .is_open (path_open[p]),
                .bad_key (path_bad[p])
            );
        end
    endgenerate

    assign ctrl_locked = ~path_open[PATH_CTRL];
    assign opt_locked  = ~path_open[PATH_OPT];
    assign ctrl_wr_ok  = path_open[PATH_CTRL];
    assign opt_wr_ok   = &path_open;
    assign bus_err     = |path_bad;

    a_r1_locked_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_locked && opt_locked && !opt_wr_ok && ctrl_field == '0));

    a_r11_err_only_on_key_write: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_wr && (bus_addr == ADR_CTRL_KEY || bus_addr == ADR_OPT_KEY)));

    a_r10_opt_ok_needs_ctrl: assert property (@(posedge clk) disable iff (rst)
        opt_wr_ok |-> ctrl_wr_ok);

    a_r6_ctrl_key_leaves_opt: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADR_CTRL_KEY) |=> $stable(opt_locked));

    a_r6_opt_key_leaves_ctrl: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADR_OPT_KEY) |=> $stable(ctrl_locked));

endmodule

// File: tb/key_lock_guard_tb.sv
`timescale 1ns/100ps
module key_lock_guard_tb;

    localparam logic [31:0] KA = 32'h4567_0123;
    localparam logic [31:0] KB = 32'hCDEF_89AB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd3;
    logic [31:0] bus_wdata = '0;
    logic        ctrl_locked, opt_locked, ctrl_wr_ok, opt_wr_ok, bus_err;
    logic [15:0] ctrl_field;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        bit          cl;
        bit          ol;
        logic [15:0] f;
        string       tag;
    } exp_t;

    exp_t q[$];

    key_lock_guard #(.KEY_A(KA), .KEY_B(KB), .CTRL_W(16), .OPT_FLAG_MODE(1'b0)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ctrl_locked(ctrl_locked), .opt_locked(opt_locked),
        .ctrl_wr_ok(ctrl_wr_ok), .opt_wr_ok(opt_wr_ok), .ctrl_field(ctrl_field),
        .bus_err(bus_err)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input bit cl, input bit ol, input logic [15:0] f, input string tag, input int due);
        exp_t e;
        e.due = due; e.cl = cl; e.ol = ol; e.f = f; e.tag = tag;
        q.push_back(e);
    endtask

    // Driver: one write strobe, checks the error pulse, queues the state expected next cycle.
    task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit e_err,
                      input bit e_cl, input bit e_ol, input logic [15:0] e_f, input string tag);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        push(e_cl, e_ol, e_f, tag, cyc + 1);
        #1;
        checks++;
        if (bus_err !== e_err) begin
            errors++;
            $display("FAIL %s bus_err during write: got %0b expected %0b", tag, bus_err, e_err);
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd3; bus_wdata = '0;
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        push(1'b1, 1'b1, 16'h0, tag, cyc);
        @(negedge clk);
    endtask

    // Monitor: pops expected state items when due and compares the ports.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (ctrl_locked !== e.cl || opt_locked !== e.ol || ctrl_field !== e.f ||
                    ctrl_wr_ok !== !e.cl || opt_wr_ok !== (!e.cl && !e.ol) || bus_err !== 1'b0) begin
                    errors++;
                    $display("FAIL %s state: got cl=%0b ol=%0b cok=%0b ook=%0b f=%h err=%0b expected cl=%0b ol=%0b cok=%0b ook=%0b f=%h err=0",
                             e.tag, ctrl_locked, opt_locked, ctrl_wr_ok, opt_wr_ok, ctrl_field, bus_err,
                             e.cl, e.ol, !e.cl, !e.cl && !e.ol, e.f);
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset("R1 reset state");
        wr(2'd2, 32'h0000_1234, 1'b0, 1'b1, 1'b1, 16'h0000, "R8 field ignored while locked");
        wr(2'd3, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 16'h0000, "R11 unused address");
        wr(2'd0, KA,            1'b0, 1'b1, 1'b1, 16'h0000, "R2 first key");
        wr(2'd3, 32'h1111_1111, 1'b0, 1'b1, 1'b1, 16'h0000, "R11 gap write");
        wr(2'd0, KB,            1'b0, 1'b0, 1'b1, 16'h0000, "R2 second key opens");
        wr(2'd2, 32'h0000_1234, 1'b0, 1'b0, 1'b1, 16'h1234, "R8 field write when open");
        wr(2'd1, KA,            1'b0, 1'b0, 1'b1, 16'h1234, "R6 opt first key");
        wr(2'd1, KB,            1'b0, 1'b0, 1'b0, 16'h1234, "R6 R10 opt open");
        wr(2'd2, 32'h4000_00AB, 1'b0, 1'b0, 1'b1, 16'h00AB, "R9 opt relock bit");
        wr(2'd2, 32'h8000_5555, 1'b0, 1'b1, 1'b1, 16'h5555, "R7 ctrl relock bit");
        wr(2'd1, KA,            1'b0, 1'b1, 1'b1, 16'h5555, "R6 opt first key ctrl locked");
        wr(2'd1, KB,            1'b0, 1'b1, 1'b0, 16'h5555, "R10 opt open ctrl locked");
        wr(2'd2, 32'h4000_0777, 1'b0, 1'b1, 1'b0, 16'h5555, "R9 R8 ignored while ctrl locked");
        wr(2'd0, KA,            1'b0, 1'b1, 1'b0, 16'h5555, "R7 reopen first key");
        wr(2'd0, KB,            1'b0, 1'b0, 1'b0, 16'h5555, "R7 R10 reopened");
        wr(2'd0, KA,            1'b1, 1'b1, 1'b0, 16'h5555, "R5 key to open ctrl path");
        wr(2'd0, KA,            1'b1, 1'b1, 1'b0, 16'h5555, "R4 barred first key");
        wr(2'd0, KB,            1'b1, 1'b1, 1'b0, 16'h5555, "R4 barred second key");
        wr(2'd2, 32'h8000_7777, 1'b0, 1'b1, 1'b0, 16'h5555, "R4 R8 barred field ignored");
        wr(2'd1, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b1, 16'h5555, "R5 R6 opt key while open");
        wr(2'd1, KA,            1'b1, 1'b1, 1'b1, 16'h5555, "R4 opt barred first key");
        wr(2'd1, KB,            1'b1, 1'b1, 1'b1, 16'h5555, "R4 opt barred second key");
        do_reset("R1 reset clears lockout");
        wr(2'd0, KA,            1'b0, 1'b1, 1'b1, 16'h0000, "R3 first key");
        wr(2'd0, 32'h1234_5678, 1'b1, 1'b1, 1'b1, 16'h0000, "R3 wrong second key");
        wr(2'd0, KB,            1'b1, 1'b1, 1'b1, 16'h0000, "R3 R4 stays barred");
        wr(2'd1, 32'h0000_0000, 1'b1, 1'b1, 1'b1, 16'h0000, "R3 opt wrong first key");
        do_reset("R1 reset again");
        wr(2'd0, KB,            1'b1, 1'b1, 1'b1, 16'h0000, "R3 keys in wrong order");
        wr(2'd0, KA,            1'b1, 1'b1, 1'b1, 16'h0000, "R3 R4 order lockout sticky");
        wr(2'd1, KA,            1'b0, 1'b1, 1'b1, 16'h0000, "R6 opt unaffected first key");
        wr(2'd1, KB,            1'b0, 1'b1, 1'b0, 16'h0000, "R6 R10 opt opens alone");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule